// File: doc/BRIEF.md
# Serial Port Register Front-End with Loopback

This block is the software-visible register file of a simple serial port. A processor reaches it through a plain strobe bus: an address, separate read and write strobes, and 32-bit write and read data. Read data is combinational from the current state, and writes take effect at the clock edge. Bytes written for transmission leave on a valid/ready byte stream toward a serializer that is not part of this block. Bytes from the line arrive on a second valid/ready stream and are held in a single-byte receive holder. There are no FIFOs.

A loopback control bit sends written bytes straight back into the receive holder, so the port can be tested without a line. Each direction raises an interrupt. A control bit per direction selects whether that interrupt is a one-cycle pulse or a sticky level. Only the low six address bits are decoded, and the status words are fixed compositions of the receive-available flag.

Top module: `uart_regfront`

## Requirements
- R1: After reset every stored register and flag is zero: all four interrupt outputs and the output stream valid are low, the input stream ready is high, and general control reads 0.
- R2: Line control (offset 0x00), general control (0x04) and baud divisor (0x28) read back exactly as written. Only address bits 5:0 are decoded, so 0x40 aliases 0x00. Offsets with no register (for example 0x2C) read zero and ignore writes.
- R3: A write to FIFO control (0x08) stores the value with bits 1 and 2 cleared, and a read returns the stored value with bit 3 cleared. Writing 0xFFFFFFFF reads back as 0xFFFFFFF1, and writing 0xE reads back as 0.
- R4: A read of modem control (0x0C) returns only bits 0 and 4 of the stored value.
- R5: Status (0x10) reads 0x6 ORed with receive-available in bit 0. FIFO status (0x18) reads receive-available in bit 0. Offsets 0x14, 0x1C and 0x20 read zero. Writes to 0x10 and 0x24 change nothing.
- R6: With general control bit 5 clear, a write to 0x20 raises the output stream valid on the next cycle, with data equal to write bits 7:0. The byte stays stable until taken with ready, and a later write while it is still pending replaces it.
- R7: With general control bit 5 set, a write to 0x20 loads bits 7:0 into the receive holder and sets receive-available, and the output stream stays idle.
- R8: Input ready equals NOT receive-available. A byte offered while the holder is full is not taken and does not alter the held byte.
- R9: A read of 0x24 returns the held byte and clears receive-available from the next cycle.
- R10: Each load of the receive holder raises the RX interrupt. If general control bit 8 is clear, the RX pulse output is high for exactly one cycle. If bit 8 is set, the RX level output goes high and stays high until a read of 0x24 or a general control write with bit 8 clear.
- R11: Each write to 0x20 raises the TX interrupt: a one-cycle TX pulse when general control bit 9 is clear, or the TX level output high when bit 9 is set. A general control write sets the TX level output to the new bit 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address; bits 5:0 decoded |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational |
| tx_valid | output | 1 | Outgoing byte pending |
| tx_ready | input | 1 | Consumer takes outgoing byte |
| tx_data | output | BYTE_W | Outgoing byte |
| rx_valid | input | 1 | Incoming byte offered |
| rx_ready | output | 1 | Holder empty, byte will be taken |
| rx_data | input | BYTE_W | Incoming byte |
| irq_rx_pulse | output | 1 | One-cycle RX interrupt |
| irq_rx_level | output | 1 | Sticky RX interrupt |
| irq_tx_pulse | output | 1 | One-cycle TX interrupt |
| irq_tx_level | output | 1 | Sticky TX interrupt |

## Verification
The hardest state to reach from the ports is a full holder while a new byte is being offered, with the level interrupt mode active. The interrupt then has to stay asserted and the held byte unchanged until software drains it. The stimulus fills the holder from the input stream in level mode and keeps offering a second byte for several cycles. It then reads the holder and checks that the first byte comes back and the level drops. A second pass uses loopback to load the holder from the bus side, so that the same flag can be observed through both status words.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;
  localparam int OFS_W = 6;

  localparam logic [OFS_W-1:0] OFS_LINE   = 6'h00;
  localparam logic [OFS_W-1:0] OFS_CTRL   = 6'h04;
  localparam logic [OFS_W-1:0] OFS_FIFO   = 6'h08;
  localparam logic [OFS_W-1:0] OFS_MODEM  = 6'h0C;
  localparam logic [OFS_W-1:0] OFS_STAT   = 6'h10;
  localparam logic [OFS_W-1:0] OFS_ERR    = 6'h14;
  localparam logic [OFS_W-1:0] OFS_FSTAT  = 6'h18;
  localparam logic [OFS_W-1:0] OFS_MSTAT  = 6'h1C;
  localparam logic [OFS_W-1:0] OFS_TXH    = 6'h20;
  localparam logic [OFS_W-1:0] OFS_RXH    = 6'h24;
  localparam logic [OFS_W-1:0] OFS_BAUD   = 6'h28;

  // general control bit positions
  localparam int CTL_LOOP  = 5;
  localparam int CTL_RXLVL = 8;
  localparam int CTL_TXLVL = 9;

  function automatic logic [31:0] fifo_store(input logic [31:0] w);
    return w & ~32'h0000_0006;
  endfunction

  function automatic logic [31:0] fifo_view(input logic [31:0] s);
    return s & ~32'h0000_0008;
  endfunction

  function automatic logic [31:0] modem_view(input logic [31:0] s);
    return s & 32'h0000_0011;
  endfunction

  function automatic logic [31:0] status_word(input logic avail);
    return 32'h0000_0006 | {31'd0, avail};
  endfunction
endpackage

// File: rtl/uart_rf_cfg.sv
module uart_rf_cfg
  import uart_rf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [OFS_W-1:0]  ofs,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] line_q,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] fifo_q,
  output logic [DATA_W-1:0] modem_q,
  output logic [DATA_W-1:0] baud_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q  <= '0;
      ctrl_q  <= '0;
      fifo_q  <= '0;
      modem_q <= '0;
      baud_q  <= '0;
    end else if (we) begin
      case (ofs)
        OFS_LINE:  line_q  <= wdata;
        OFS_CTRL:  ctrl_q  <= wdata;
        OFS_FIFO:  fifo_q  <= fifo_store(wdata);
        OFS_MODEM: modem_q <= wdata;
        OFS_BAUD:  baud_q  <= wdata;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/uart_rf_rxhold.sv
module uart_rf_rxhold #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lb_load,
  input  logic [BYTE_W-1:0] lb_byte,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  output logic              in_ready,
  input  logic              rd_clr,
  input  logic              lvl_mode,
  input  logic              ctrl_wr,
  input  logic              ctrl_new_lvl,
  output logic              avail,
  output logic [BYTE_W-1:0] held,
  output logic              load_ev,
  output logic              irq_pulse,
  output logic              irq_level
);
  logic in_take;

  assign in_ready = !avail;
  assign in_take  = in_valid && in_ready;
  assign load_ev  = lb_load || in_take;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      avail     <= 1'b0;
      held      <= '0;
      irq_pulse <= 1'b0;
      irq_level <= 1'b0;
    end else begin
      // bus-side loopback has priority over the input stream
      if (lb_load)      held <= lb_byte;
      else if (in_take) held <= in_byte;

      if (load_ev)     avail <= 1'b1;
      else if (rd_clr) avail <= 1'b0;

      irq_pulse <= load_ev && !lvl_mode;

      if (load_ev && lvl_mode)              irq_level <= 1'b1;
      else if (ctrl_wr && !ctrl_new_lvl)    irq_level <= 1'b0;
      else if (rd_clr && lvl_mode)          irq_level <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_rf_txpath.sv
module uart_rf_txpath #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_wr,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              loop_en,
  input  logic              lvl_mode,
  input  logic              ctrl_wr,
  input  logic              ctrl_new_lvl,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_byte,
  output logic              irq_pulse,
  output logic              irq_level
);
  logic emit;

  assign emit = tx_wr && !loop_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_byte  <= '0;
      irq_pulse <= 1'b0;
      irq_level <= 1'b0;
    end else begin
      if (emit) begin
        out_valid <= 1'b1;
        out_byte  <= tx_byte;
      end else if (out_valid && out_ready) begin
        out_valid <= 1'b0;
      end

      irq_pulse <= tx_wr && !lvl_mode;

      if (ctrl_wr)               irq_level <= ctrl_new_lvl;
      else if (tx_wr && lvl_mode) irq_level <= 1'b1;
    end
  end
endmodule

// File: rtl/uart_regfront.sv
module uart_regfront
  import uart_rf_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [BYTE_W-1:0] tx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              irq_rx_pulse,
  output logic              irq_rx_level,
  output logic              irq_tx_pulse,
  output logic              irq_tx_level
);
  localparam int PAD_W = DATA_W - BYTE_W;

  logic [OFS_W-1:0]  ofs;
  logic [DATA_W-1:0] line_q, ctrl_q, fifo_q, modem_q, baud_q;
  logic [BYTE_W-1:0] held;

  // named internal events, used by the bound checker
  logic ev_ctrl_wr, ev_tx_wr, ev_rx_rd, ev_rx_load, rx_avail;
  logic loop_en, rx_lvl_mode, tx_lvl_mode;

  assign ofs         = bus_addr[OFS_W-1:0];
  assign ev_ctrl_wr  = bus_wr && (ofs == OFS_CTRL);
  assign ev_tx_wr    = bus_wr && (ofs == OFS_TXH);
  assign ev_rx_rd    = bus_rd && (ofs == OFS_RXH);
  assign loop_en     = ctrl_q[CTL_LOOP];
  assign rx_lvl_mode = ctrl_q[CTL_RXLVL];
  assign tx_lvl_mode = ctrl_q[CTL_TXLVL];

  uart_rf_cfg #(.DATA_W(DATA_W)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (bus_wr),
    .ofs     (ofs),
    .wdata   (bus_wdata),
    .line_q  (line_q),
    .ctrl_q  (ctrl_q),
    .fifo_q  (fifo_q),
    .modem_q (modem_q),
    .baud_q  (baud_q)
  );

  uart_rf_rxhold #(.BYTE_W(BYTE_W)) u_rx (
    .clk          (clk),
    .rst_n        (rst_n),
    .lb_load      (ev_tx_wr && loop_en),
    .lb_byte      (bus_wdata[BYTE_W-1:0]),
    .in_valid     (rx_valid),
    .in_byte      (rx_data),
    .in_ready     (rx_ready),
    .rd_clr       (ev_rx_rd),
    .lvl_mode     (rx_lvl_mode),
    .ctrl_wr      (ev_ctrl_wr),
    .ctrl_new_lvl (bus_wdata[CTL_RXLVL]),
    .avail        (rx_avail),
    .held         (held),
    .load_ev      (ev_rx_load),
    .irq_pulse    (irq_rx_pulse),
    .irq_level    (irq_rx_level)
  );

  uart_rf_txpath #(.BYTE_W(BYTE_W)) u_tx (
    .clk          (clk),
    .rst_n        (rst_n),
    .tx_wr        (ev_tx_wr),
    .tx_byte      (bus_wdata[BYTE_W-1:0]),
    .loop_en      (loop_en),
    .lvl_mode     (tx_lvl_mode),
    .ctrl_wr      (ev_ctrl_wr),
    .ctrl_new_lvl (bus_wdata[CTL_TXLVL]),
    .out_ready    (tx_ready),
    .out_valid    (tx_valid),
    .out_byte     (tx_data),
    .irq_pulse    (irq_tx_pulse),
    .irq_level    (irq_tx_level)
  );

  always_comb begin
    case (ofs)
      OFS_LINE:  bus_rdata = line_q;
      OFS_CTRL:  bus_rdata = ctrl_q;
      OFS_FIFO:  bus_rdata = fifo_view(fifo_q);
      OFS_MODEM: bus_rdata = modem_view(modem_q);
      OFS_STAT:  bus_rdata = status_word(rx_avail);
      OFS_FSTAT: bus_rdata = {{(DATA_W-1){1'b0}}, rx_avail};
      OFS_RXH:   bus_rdata = {{PAD_W{1'b0}}, held};
      OFS_BAUD:  bus_rdata = baud_q;
      default:   bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/uart_regfront_chk.sv
module uart_regfront_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [BYTE_W-1:0] tx_data,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic              irq_rx_pulse,
  input logic              irq_rx_level,
  input logic              irq_tx_pulse,
  input logic              irq_tx_level,
  input logic              ev_tx_wr,
  input logic              ev_rx_load,
  input logic              loop_en,
  input logic              rx_lvl_mode
);
  AST_RX_TAKE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready) |=> !rx_ready); // R8

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !ev_tx_wr) |=> (tx_valid && $stable(tx_data))); // R6

  AST_LOOP_NO_TX: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_tx_wr && loop_en && !tx_valid) |=> !tx_valid); // R7

  AST_RX_PULSE_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rx_load && !rx_lvl_mode) |=> irq_rx_pulse); // R10

  AST_RX_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx_pulse |-> !irq_rx_level); // R10

  AST_TX_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    irq_tx_pulse |-> !irq_tx_level); // R11

  AST_STATUS_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr[5:0] == 6'h10) |-> (bus_rdata[DATA_W-1:1] == 'd3)); // R5
endmodule

bind uart_regfront uart_regfront_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BYTE_W(BYTE_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_addr     (bus_addr),
  .bus_rd       (bus_rd),
  .bus_rdata    (bus_rdata),
  .tx_valid     (tx_valid),
  .tx_ready     (tx_ready),
  .tx_data      (tx_data),
  .rx_valid     (rx_valid),
  .rx_ready     (rx_ready),
  .irq_rx_pulse (irq_rx_pulse),
  .irq_rx_level (irq_rx_level),
  .irq_tx_pulse (irq_tx_pulse),
  .irq_tx_level (irq_tx_level),
  .ev_tx_wr     (ev_tx_wr),
  .ev_rx_load   (ev_rx_load),
  .loop_en      (loop_en),
  .rx_lvl_mode  (rx_lvl_mode)
);

// File: tb/uart_regfront_tb.sv
module uart_regfront_tb;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic              wr;
    logic [7:0]        req;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;   // write data, or expected read data
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 8'd2, 12'h000, 32'hA5A5_1234},  // R2 line control
    '{1'b0, 8'd2, 12'h000, 32'hA5A5_1234},
    '{1'b1, 8'd2, 12'h028, 32'h0000_01B0},  // R2 baud divisor
    '{1'b0, 8'd2, 12'h028, 32'h0000_01B0},
    '{1'b1, 8'd3, 12'h008, 32'hFFFF_FFFF},  // R3 fifo control masks
    '{1'b0, 8'd3, 12'h008, 32'hFFFF_FFF1},
    '{1'b1, 8'd3, 12'h008, 32'h0000_000E},
    '{1'b0, 8'd3, 12'h008, 32'h0000_0000},
    '{1'b1, 8'd4, 12'h00C, 32'hFFFF_FFFF},  // R4 modem control
    '{1'b0, 8'd4, 12'h00C, 32'h0000_0011},
    '{1'b1, 8'd5, 12'h010, 32'hFFFF_FFFF},  // R5 status ignores writes
    '{1'b0, 8'd5, 12'h010, 32'h0000_0006},
    '{1'b0, 8'd5, 12'h014, 32'h0000_0000},
    '{1'b0, 8'd5, 12'h01C, 32'h0000_0000},
    '{1'b1, 8'd2, 12'h02C, 32'h0000_1234},  // R2 unmapped
    '{1'b0, 8'd2, 12'h02C, 32'h0000_0000},
    '{1'b1, 8'd2, 12'h068, 32'h0000_0077},  // R2 alias of baud
    '{1'b0, 8'd2, 12'h028, 32'h0000_0077}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic              bus_wr = 1'b0;
  logic              bus_rd = 1'b0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic              tx_valid;
  logic              tx_ready = 1'b0;
  logic [BYTE_W-1:0] tx_data;
  logic              rx_valid = 1'b0;
  logic              rx_ready;
  logic [BYTE_W-1:0] rx_data = '0;
  logic              irq_rx_pulse, irq_rx_level, irq_tx_pulse, irq_tx_level;

  int checks = 0;
  int errors = 0;
  logic [DATA_W-1:0] rd;

  always #2 clk = ~clk;

  uart_regfront #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .irq_rx_pulse(irq_rx_pulse), .irq_rx_level(irq_rx_level),
    .irq_tx_pulse(irq_tx_pulse), .irq_tx_level(irq_tx_level)
  );

  task automatic check(input string tag, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic offer_byte(input logic [BYTE_W-1:0] b, input int cycles);
    @(negedge clk);
    rx_data = b; rx_valid = 1'b1;
    repeat (cycles) @(negedge clk);
    rx_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 tx_valid", tx_valid, 0);
    check("R1 rx_ready", rx_ready, 1);
    check("R1 irqs", {irq_rx_pulse, irq_rx_level, irq_tx_pulse, irq_tx_level}, 0);
    bus_read(12'h004, rd); check("R1 ctrl", rd, 0);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) bus_write(VECS[i].addr, VECS[i].data);
      else begin
        bus_read(VECS[i].addr, rd);
        check($sformatf("R%0d table %0d", VECS[i].req, i), rd, VECS[i].data);
      end
    end
    bus_read(12'h040, rd); check("R2 alias 0x40", rd, 32'hA5A5_1234);

    // R6 transmit path, R11 pulse
    bus_write(12'h020, 32'h0000_01C3);
    check("R6 tx_valid", tx_valid, 1);
    check("R6 tx_data", tx_data, 8'hC3);
    check("R11 tx pulse", irq_tx_pulse, 1);
    @(negedge clk);
    check("R11 tx pulse one cycle", irq_tx_pulse, 0);
    check("R6 held", {tx_valid, tx_data}, {1'b1, 8'hC3});
    bus_write(12'h020, 32'h0000_005A);
    check("R6 overwrite", tx_data, 8'h5A);
    tx_ready = 1'b1;
    @(negedge clk);
    check("R6 taken", tx_valid, 0);

    // R11 level mode
    bus_write(12'h004, 32'h0000_0200);
    check("R11 ctrl sets level", irq_tx_level, 1);
    bus_write(12'h004, 32'h0);
    check("R11 ctrl clears level", irq_tx_level, 0);
    bus_write(12'h004, 32'h0000_0200);
    bus_write(12'h004, 32'h0000_0200);
    bus_write(12'h020, 32'h11);
    check("R11 level no pulse", {irq_tx_level, irq_tx_pulse}, 2'b10);
    bus_write(12'h004, 32'h0);
    @(negedge clk);

    // R7 loopback, R9 holding read
    bus_write(12'h004, 32'h0000_0020);
    bus_write(12'h020, 32'h0000_003C);
    check("R7 no tx", tx_valid, 0);
    check("R7 rx pulse", irq_rx_pulse, 1);
    check("R7 rx_ready low", rx_ready, 0);
    bus_read(12'h010, rd); check("R5 status avail", rd, 32'h7);
    bus_read(12'h018, rd); check("R5 fifo status", rd, 32'h1);
    bus_write(12'h024, 32'hFF);
    bus_read(12'h024, rd); check("R9 held byte", rd, 32'h3C);
    check("R9 avail cleared", rx_ready, 1);
    bus_read(12'h010, rd); check("R9 status empty", rd, 32'h6);

    // R8 / R10 level mode from input stream
    bus_write(12'h004, 32'h0000_0100);
    offer_byte(8'h81, 1);
    check("R10 level set", {irq_rx_level, irq_rx_pulse}, 2'b10);
    check("R8 full", rx_ready, 0);
    offer_byte(8'h99, 3);
    check("R10 level held", irq_rx_level, 1);
    bus_read(12'h024, rd); check("R8 byte kept", rd, 32'h81);
    check("R10 read clears level", irq_rx_level, 0);

    // R10 ctrl write with bit 8 clear drops level, data still held
    offer_byte(8'h42, 1);
    check("R10 level again", irq_rx_level, 1);
    bus_write(12'h004, 32'h0);
    check("R10 ctrl clears level", irq_rx_level, 0);
    bus_read(12'h010, rd); check("R10 still avail", rd, 32'h7);
    bus_read(12'h024, rd); check("R9 second byte", rd, 32'h42);

    // R10 pulse mode from input stream
    offer_byte(8'hE7, 1);
    check("R10 rx pulse", {irq_rx_pulse, irq_rx_level}, 2'b10);
    @(negedge clk);
    check("R10 pulse one cycle", irq_rx_pulse, 0);
    bus_read(12'h024, rd); check("R8 stream byte", rd, 32'hE7);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule